// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outgoing request path of a host-to-link bridge. It rewrites 64-bit host addresses into link addresses. Software programs up to eight windows. Each window holds a 64-bit match value, a 64-bit per-bit mask, a 64-bit remap value and a 32-bit actions word. Every address presented on the request input is compared against all enabled windows in parallel.

When a window hits, the masked bits of the address are replaced by the remap value and the window's actions word is passed along. The actions word carries the transaction type and any further attributes. When no window hits, or when translation is switched off globally, the address leaves unchanged with a zero actions word (a memory-type request). The result is registered and appears one cycle after the request, together with a valid flag.

Software reaches the block through a 32-bit register port that writes on a strobe and reads back without delay. A window is armed by bit 0 of its low match word, so the usual sequence is to write every field first and to rewrite the low match word with bit 0 set as the last step.

Top module: `obw_xlate`

## Requirements
- R1: After reset, out_valid is 0 and every register location reads 0.
- R2: Window n's registers sit at byte offset 0x20*n. Within that block the layout is: 0x00 match low, 0x04 match high, 0x08 remap low, 0x0C remap high, 0x10 mask low, 0x14 mask high, 0x18 actions. Slot 0x1C reads 0 and ignores writes. The control register sits at 0x100. Only its bit 6 is stored; every other bit of it reads 0. Each stored word reads back exactly as written. cfg_addr bits 1:0 are ignored.
- R3: A window takes part in matching only while bit 0 of its low match word is 1. Clearing that bit makes the window miss for every address.
- R4: An enabled window hits when every address bit whose mask bit is 1 equals the corresponding match bit. Bit 0 is excluded from the comparison, whatever its mask bit holds.
- R5: On a hit, each out_addr bit comes from the remap value where the effective mask (the mask with bit 0 forced to 0) is 1, and from the input address where it is 0.
- R6: When several enabled windows hit, the lowest-numbered one is used.
- R7: When no window hits, out_addr equals the input address, out_hit is 0, out_win is 0 and out_actions is 0.
- R8: While control bit 6 is 0, every request passes through untranslated with out_hit 0, whatever the windows hold.
- R9: A request accepted with in_valid at a clock edge produces out_valid = 1 for exactly the following cycle. With in_valid low, out_valid is 0 in the next cycle.
- R10: On a hit, out_win gives the selected window's index and out_actions gives its full actions word. The type field in bits 3:0 is 0x0 for memory and 0x4 for I/O; higher bits, from bit 20 upward, pass through as further attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (9) | Register byte offset, shared by write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| in_valid | input | 1 | Request address valid |
| in_addr | input | 64 | Host address to translate |
| out_valid | output | 1 | Translated result valid, one cycle after in_valid |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | A window was used |
| out_win | output | $clog2(NWIN) (3) | Index of the window used |
| out_actions | output | 32 | Actions word of the window used, 0 on a miss |

## Verification
The assertions assume that reset holds in_valid low, so the first cycle after reset never carries a result from before reset. They also assume that the window set seen at a request's clock edge is the one its result reflects; the comparison of each result with the hit vector of the previous cycle depends on that. The stimulus keeps within these limits. It holds in_valid low through reset and during every register access, and it issues each configuration write in a cycle with no request, so no result straddles a change of the window set.

// File: rtl/obw_pkg.sv
package obw_pkg;

    localparam int ADDR_W      = 64;
    localparam int WORD_W      = 32;
    localparam int WIN_BYTES   = 32;
    localparam int CTRL_EN_BIT = 6;

    typedef enum logic [2:0] {
        F_MATCH_LO = 3'd0,
        F_MATCH_HI = 3'd1,
        F_REMAP_LO = 3'd2,
        F_REMAP_HI = 3'd3,
        F_MASK_LO  = 3'd4,
        F_MASK_HI  = 3'd5,
        F_ACTIONS  = 3'd6,
        F_RSVD     = 3'd7
    } field_e;

    typedef struct packed {
        logic [ADDR_W-1:0] match;
        logic [ADDR_W-1:0] remap;
        logic [ADDR_W-1:0] mask;
        logic [WORD_W-1:0] actions;
    } win_cfg_t;

    // Bit 0 doubles as the enable, so it never takes part in compare or remap.
    function automatic logic [ADDR_W-1:0] eff_mask(input win_cfg_t w);
        return w.mask & ~{{(ADDR_W-1){1'b0}}, 1'b1};
    endfunction

    function automatic logic win_hit(input win_cfg_t w, input logic [ADDR_W-1:0] a);
        return w.match[0] && (((a ^ w.match) & eff_mask(w)) == '0);
    endfunction

    function automatic logic [ADDR_W-1:0] remap_addr(input win_cfg_t w,
                                                     input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = eff_mask(w);
        return (w.remap & m) | (a & ~m);
    endfunction

endpackage

// File: rtl/obw_regfile.sv
module obw_regfile
    import obw_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CFG_AW = $clog2(NWIN) + 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_wr,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]            cfg_wdata,
    output logic [WORD_W-1:0]            cfg_rdata,
    output win_cfg_t [NWIN-1:0]          win,
    output logic                         glb_en
);
    localparam int IW = $clog2(NWIN);

    logic          ctrl_sel;
    logic          ctrl_hit;
    logic [IW-1:0] widx;
    field_e        fld;

    assign ctrl_sel = cfg_addr[CFG_AW-1];
    assign ctrl_hit = ctrl_sel && (cfg_addr[CFG_AW-2:2] == '0);
    assign widx     = cfg_addr[CFG_AW-2 -: IW];
    assign fld      = field_e'(cfg_addr[4:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en <= 1'b0;
        end else if (cfg_wr && ctrl_hit) begin
            glb_en <= cfg_wdata[CTRL_EN_BIT];
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic wsel;
        assign wsel = cfg_wr && !ctrl_sel && (widx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                win[g] <= '0;
            end else if (wsel) begin
                case (fld)
                    F_MATCH_LO: win[g].match[31:0]  <= cfg_wdata;
                    F_MATCH_HI: win[g].match[63:32] <= cfg_wdata;
                    F_REMAP_LO: win[g].remap[31:0]  <= cfg_wdata;
                    F_REMAP_HI: win[g].remap[63:32] <= cfg_wdata;
                    F_MASK_LO:  win[g].mask[31:0]   <= cfg_wdata;
                    F_MASK_HI:  win[g].mask[63:32]  <= cfg_wdata;
                    F_ACTIONS:  win[g].actions      <= cfg_wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        win_cfg_t w;
        w         = win[widx];
        cfg_rdata = '0;
        if (ctrl_sel) begin
            if (ctrl_hit) cfg_rdata[CTRL_EN_BIT] = glb_en;
        end else begin
            case (fld)
                F_MATCH_LO: cfg_rdata = w.match[31:0];
                F_MATCH_HI: cfg_rdata = w.match[63:32];
                F_REMAP_LO: cfg_rdata = w.remap[31:0];
                F_REMAP_HI: cfg_rdata = w.remap[63:32];
                F_MASK_LO:  cfg_rdata = w.mask[31:0];
                F_MASK_HI:  cfg_rdata = w.mask[63:32];
                F_ACTIONS:  cfg_rdata = w.actions;
                default:    cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/obw_match.sv
module obw_match
    import obw_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  win_cfg_t [NWIN-1:0] win,
    output logic [NWIN-1:0]     hit_vec
);
    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        assign hit_vec[g] = win_hit(win[g], addr);
    end
endmodule

// File: rtl/obw_select.sv
module obw_select
    import obw_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int IW  = $clog2(NWIN)
) (
    input  logic [ADDR_W-1:0]   addr,
    input  win_cfg_t [NWIN-1:0] win,
    input  logic [NWIN-1:0]     hit_vec,
    input  logic                enable,
    output logic                sel_hit,
    output logic [IW-1:0]       sel_idx,
    output logic [ADDR_W-1:0]   sel_addr,
    output logic [WORD_W-1:0]   sel_actions
);
    always_comb begin
        logic          found;
        logic [IW-1:0] idx;
        found = 1'b0;
        idx   = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        sel_hit     = enable && found;
        sel_idx     = sel_hit ? idx : '0;
        sel_addr    = sel_hit ? remap_addr(win[idx], addr) : addr;
        sel_actions = sel_hit ? win[idx].actions : '0;
    end
endmodule

// File: rtl/obw_xlate.sv
module obw_xlate
    import obw_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CFG_AW = $clog2(NWIN) + 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic                    in_valid,
    input  logic [63:0]             in_addr,
    output logic                    out_valid,
    output logic [63:0]             out_addr,
    output logic                    out_hit,
    output logic [$clog2(NWIN)-1:0] out_win,
    output logic [31:0]             out_actions
);
    localparam int IW = $clog2(NWIN);

    win_cfg_t [NWIN-1:0] win;
    logic                glb_en;
    logic [NWIN-1:0]     hit_vec;
    logic                sel_hit;
    logic [IW-1:0]       sel_idx;
    logic [ADDR_W-1:0]   sel_addr;
    logic [WORD_W-1:0]   sel_actions;

    obw_regfile #(.NWIN(NWIN), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win(win), .glb_en(glb_en)
    );

    obw_match #(.NWIN(NWIN)) u_match (
        .addr(in_addr), .win(win), .hit_vec(hit_vec)
    );

    obw_select #(.NWIN(NWIN)) u_sel (
        .addr(in_addr), .win(win), .hit_vec(hit_vec), .enable(glb_en),
        .sel_hit(sel_hit), .sel_idx(sel_idx), .sel_addr(sel_addr),
        .sel_actions(sel_actions)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_hit     <= 1'b0;
            out_win     <= '0;
            out_actions <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr    <= sel_addr;
                out_hit     <= sel_hit;
                out_win     <= sel_idx;
                out_actions <= sel_actions;
            end
        end
    end

endmodule

// File: rtl/obw_xlate_chk.sv
module obw_xlate_chk #(
    parameter int NWIN = 8,
    localparam int IW  = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [63:0]     in_addr,
    input logic            glb_en,
    input logic [NWIN-1:0] hit_vec,
    input logic            out_valid,
    input logic [63:0]     out_addr,
    input logic            out_hit,
    input logic [IW-1:0]   out_win,
    input logic [31:0]     out_actions
);
    logic [NWIN-1:0] below;
    assign below = (NWIN'(1) << out_win) - NWIN'(1);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                        // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                      // R9
    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !glb_en) |=> (!out_hit && out_addr == $past(in_addr))); // R8
    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit_vec == '0) |=>
        (!out_hit && out_actions == 32'd0 && out_addr == $past(in_addr))); // R7
    AST_HIT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && glb_en && hit_vec != '0) |=>
        (out_hit && (($past(hit_vec) >> out_win) & NWIN'(1)) != '0));  // R4
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hit) |-> (($past(hit_vec) & below) == '0));  // R6
endmodule

bind obw_xlate obw_xlate_chk #(.NWIN(NWIN)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .glb_en(glb_en), .hit_vec(hit_vec), .out_valid(out_valid),
    .out_addr(out_addr), .out_hit(out_hit), .out_win(out_win),
    .out_actions(out_actions)
);

// File: tb/obw_xlate_test.sv
module obw_xlate_test;
    localparam int NWIN   = 8;
    localparam int CFG_AW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_hit;
    logic [2:0]  out_win;
    logic [31:0] out_actions;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] sh [NWIN][8];   // shadow of the window words
    logic        sh_en;

    always #2.5 clk = ~clk;

    obw_xlate #(.NWIN(NWIN), .CFG_AW(CFG_AW)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
        .out_hit(out_hit), .out_win(out_win), .out_actions(out_actions)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = CFG_AW'(a); cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a >= 'h100) begin
            if (a == 'h100) sh_en = d[6];
        end else if (((a >> 2) & 7) != 7) sh[a >> 5][(a >> 2) & 7] = d;
    endtask

    task automatic rd_check(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = CFG_AW'(a);
        #1;
        check(req, {96'd0, cfg_rdata}, {96'd0, exp});
    endtask

    function automatic logic [31:0] exp_word(input int a);
        if (a == 'h100) return {25'd0, sh_en, 6'd0};
        if (a > 'h100) return 32'd0;
        if (((a >> 2) & 7) == 7) return 32'd0;
        return sh[a >> 5][(a >> 2) & 7];
    endfunction

    // Expected result: {hit, win, actions, addr}
    task automatic model(input logic [63:0] a, output logic hit, output int idx,
                         output logic [31:0] act, output logic [63:0] oa,
                         output int nhits);
        hit = 0; idx = 0; act = 0; oa = a; nhits = 0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            logic [63:0] m, k, r;
            m = {sh[w][1], sh[w][0]};
            r = {sh[w][3], sh[w][2]};
            k = {sh[w][5], sh[w][4]} & ~64'd1;
            if (m[0] && ((a & k) == (m & k))) begin
                nhits++;
                hit = 1; idx = w; act = sh[w][6];
                oa = (r & k) | (a & ~k);
            end
        end
        if (!sh_en) begin hit = 0; idx = 0; act = 0; oa = a; end
    endtask

    task automatic xlate(input logic [63:0] a);
        logic hit; int idx; logic [31:0] act; logic [63:0] oa; int nh;
        string req;
        model(a, hit, idx, act, oa, nh);
        if (!sh_en) req = "R8";
        else if (!hit) req = "R7 miss";
        else if (nh > 1) req = "R6 R5 R10";
        else req = "R4 R5 R10";
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, out_hit, 26'd0, out_win, out_actions, out_addr},
                   {1'b1, hit, 26'd0, 3'(idx), act, oa});
    endtask

    function automatic logic [63:0] sweep_addr(input int k);
        logic [31:0] lo;
        lo = (32'(k) << 26) | ((32'(k) * 32'h0001_2345) & 32'h03FF_FFFE) | 32'(k & 1);
        return {((k % 3) == 0) ? 32'd1 : 32'd0, lo};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NWIN; w++) for (int f = 0; f < 8; f++) sh[w][f] = 0;
        sh_en = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        check("R1 out_valid", {127'd0, out_valid}, 128'd0);
        for (int a = 0; a <= 'h10C; a += 4) rd_check("R1 reset read", a, 32'd0);

        // Program windows: all fields first, then arm through match low bit 0
        for (int i = 0; i < NWIN; i++) begin
            logic [31:0] mlo;
            wr(i*32 + 'h04, (i == 4) ? 32'd1 : 32'd0);
            wr(i*32 + 'h08, 32'h5555_5555 ^ (32'(i) * 32'h1111_0000));
            wr(i*32 + 'h0C, 32'h100 + 32'(i));
            wr(i*32 + 'h10, (i == 7) ? 32'hF000_0000 : (i == 0) ? 32'hF800_0001 : 32'hF800_0000);
            wr(i*32 + 'h14, 32'hFFFF_FFFF);
            wr(i*32 + 'h18, ((i & 1) ? 32'h4 : 32'h0) | (32'(i) << 20));
            wr(i*32 + 'h1C, 32'hDEAD_BEEF);
            mlo = (i == 7) ? (32'd2 << 27) : (32'(i) << 27);
            wr(i*32 + 'h00, mlo);
            wr(i*32 + 'h00, (i == 6) ? mlo : (mlo | 32'd1));
        end
        wr('h104, 32'hFFFF_FFFF);
        wr('h100, 32'hFFFF_FFFF);
        // R2: readback of map, reserved slot, control bit 6 only
        for (int a = 0; a <= 'h10C; a += 4) rd_check("R2 readback", a, exp_word(a));
        rd_check("R2 unaligned", 'h10B, exp_word('h108));

        // R8: global off
        wr('h100, 32'h0);
        for (int k = 0; k < 16; k++) xlate(sweep_addr(k));

        // Main sweep with translation on
        wr('h100, 32'h40);
        for (int k = 0; k < 64; k++) xlate(sweep_addr(k));

        // R3: disarm window 2; region 2 then falls to window 7 (R6)
        wr('h40, 32'd2 << 27);
        for (int k = 0; k < 16; k++) xlate(sweep_addr(k));
        xlate(64'h0000_0000_1234_5678);

        // R9: one-cycle valid pulse
        @(negedge clk); in_valid = 1'b1; in_addr = 64'h55;
        @(negedge clk); in_valid = 1'b0;
        check("R9 pulse high", {127'd0, out_valid}, 128'd1);
        @(negedge clk);
        check("R9 pulse low", {127'd0, out_valid}, 128'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule